// File: doc/BRIEF.md
# Priority Broadcast Frame Scheduler

This block builds the frames of the asynchronous command lane of a two-lane timing and trigger link and shifts them out one bit per 40 MHz clock. It serves three request classes. A priority broadcast is a time-critical short message such as burst start, burst end or a warning. An ordinary trigger broadcast is a short message carrying a 6-bit trigger type. An addressed long frame comes from a 128-entry queue that a trigger-data source and a software source can both fill.

A priority broadcast is accepted together with an inhibit length. From that clock on, no lower-priority frame may begin, and the priority frame starts a fixed number of clocks later. The default inhibit length is 16 clocks (400 ns). A legacy length of 44 clocks is also supported, and it is long enough to let a long frame already in flight finish first. A frame that has begun is always completed. Frames of any class follow each other without idle bits when they are ready.

Top module: `chb_frame_sched`

## Requirements
- R1: The serial line idles high whenever no frame is being sent. After reset `q_full` is 0 and `drop_cnt` is 0.
- R2: A short frame is 16 bits, sent most significant first: 0 (start), 0 (short format), data byte b7..b0, check bits c4..c0, 1 (stop). The data byte is {code[5:0], 2'b00}, so its two low bits (the receiver reset bits) are always zero.
- R3: Number the payload bits j from the least significant bit. Give bit j the j-th integer, counting from 3, that is not a power of two. Check bit ci (i below k) is the XOR of every payload bit whose number has bit i set. The top check bit ck is the XOR of all payload bits and all lower check bits. Short frames use k=4 and 8 payload bits; long frames use k=6 and 32 payload bits.
- R4: A long frame is 42 bits, sent most significant first: 0, 1, address[13:0], ext, rsv, sub[7:0], data[7:0], c6..c0, 1. These fields come from the queue word as rsv=[31], address=[30:17], ext=[16], sub=[15:8] and data=[7:0]. The payload is {address, ext, rsv, sub, data}.
- R5: A priority request is accepted only when no priority frame is pending, and `inhibit_len` is sampled on that clock. If the line is free by then, the start bit of the priority frame appears `inhibit_len`+1 clocks after the request is sampled.
- R6: A frame that has begun is never cut short. No trigger or queue frame starts in the clock a priority request is sampled, nor while a priority frame is pending. With a 44-clock inhibit, a long frame already in flight completes and the priority frame still starts on time.
- R7: Priority frames go before trigger frames, and trigger frames go before queue frames. The next frame starts on the clock right after the previous stop bit.
- R8: A priority request made while another is pending is ignored. The same applies to a trigger request made while another is pending.
- R9: Queue words leave in the order they were written. The queue holds 128 words.
- R10: If both sources write in the same clock, the trigger-data word is stored first. If only one slot is free, only the trigger-data word is stored.
- R11: `q_full` is high while 128 words are held. Every write that finds no slot is dropped and adds one to `drop_cnt`, which saturates at its maximum.
- R12: On an idle line, a trigger request or a queue write sampled on one clock puts its start bit on the line one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| inhibit_len | input | INH_W | Inhibit length in clocks, sampled when a priority request is accepted |
| pri_req | input | 1 | Priority broadcast request pulse |
| pri_code | input | 6 | Code carried by the priority broadcast |
| trg_req | input | 1 | Trigger broadcast request pulse |
| trg_code | input | 6 | Trigger type |
| hw_wr | input | 1 | Queue write from the trigger-data source |
| hw_wdata | input | 32 | Queue word from the trigger-data source |
| sw_wr | input | 1 | Queue write from the software source |
| sw_wdata | input | 32 | Queue word from the software source |
| ser_out | output | 1 | Serial command lane |
| q_full | output | 1 | Queue full |
| drop_cnt | output | CNT_W | Count of dropped queue writes |

## Verification
The bench times priority launches against two inhibit lengths. One of these cases starts the priority request one clock into a long frame. A design that cut the frame, or that counted the inhibit from the end of the frame, would put the start bit on the wrong clock. It sends trigger and queue traffic during an inhibit window and expects it to follow the priority frame back to back, in class order. A design that let lower traffic slip into the window would show a start bit early. It also fills the queue with paired writes so that the last free slot meets a simultaneous pair. A wrong ordering, a lost trigger-data word or a miscounted drop then shows up in the frames that are drained and in `drop_cnt`.

// File: rtl/chb_pkg.sv
package chb_pkg;

    localparam int FRM_W      = 42;
    localparam int SHORT_BITS = 16;
    localparam int LONG_BITS  = 42;
    localparam int QWORD_W    = 32;
    localparam int LEN_W      = $clog2(FRM_W + 1);

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PRI  = 2'd1,
        SRC_TRG  = 2'd2,
        SRC_QUE  = 2'd3
    } src_e;

    // queue word layout: rsv at the top, then address, ext, sub, data
    typedef struct packed {
        logic        rsv;
        logic [13:0] addr;
        logic        ext;
        logic [7:0]  sub;
        logic [7:0]  data;
    } qword_t;

    // check bits: low k bits are position parities, bit k is overall parity
    function automatic logic [6:0] chk_bits(input logic [31:0] pl, input int n, input int k);
        logic [6:0] c;
        logic       par;
        int         pos;
        c   = '0;
        par = 1'b0;
        pos = 2;
        for (int j = 0; j < 32; j++) begin
            if (j < n) begin
                pos++;
                if ((pos & (pos - 1)) == 0) pos++;
                for (int i = 0; i < 6; i++) begin
                    if (i < k && ((pos >> i) & 1) == 1 && pl[j]) c[i] = ~c[i];
                end
                par = par ^ pl[j];
            end
        end
        for (int i = 0; i < 6; i++) begin
            if (i < k) par = par ^ c[i];
        end
        c[k] = par;
        return c;
    endfunction

    // short frame, left-aligned in the shifter width, idle ones below
    function automatic logic [FRM_W-1:0] short_frame(input logic [5:0] code);
        logic [7:0] b;
        logic [6:0] c;
        b = {code, 2'b00};
        c = chk_bits({24'd0, b}, 8, 4);
        return {2'b00, b, c[4:0], 1'b1, {(FRM_W - SHORT_BITS){1'b1}}};
    endfunction

    function automatic logic [FRM_W-1:0] long_frame(input qword_t w);
        logic [31:0] pl;
        logic [6:0]  c;
        pl = {w.addr, w.ext, w.rsv, w.sub, w.data};
        c  = chk_bits(pl, 32, 6);
        return {2'b01, pl, c, 1'b1};
    endfunction

endpackage

// File: rtl/chb_queue.sv
module chb_queue #(
    parameter int DEPTH = 128,
    parameter int W     = 32,
    parameter int CW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wa,
    input  logic [W-1:0]  da,
    input  logic          wb,
    input  logic [W-1:0]  db,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] drops
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr, wptr_b;
    logic [AW:0]   count, free;
    logic          acc_a, acc_b;
    logic [1:0]    nd;
    logic [CW:0]   dsum;

    assign free   = (AW+1)'(DEPTH) - count;
    assign acc_a  = wa && (free != '0);
    assign acc_b  = wb && (acc_a ? (free >= (AW+1)'(2)) : (free != '0));
    assign wptr_b = wptr + AW'(acc_a);
    assign empty  = (count == '0);
    assign full   = (count == (AW+1)'(DEPTH));
    assign rdata  = mem[rptr];
    assign nd     = {1'b0, wa && !acc_a} + {1'b0, wb && !acc_b};
    assign dsum   = {1'b0, drops} + (CW+1)'(nd);

    always_ff @(posedge clk) begin
        if (acc_a) mem[wptr]   <= da;
        if (acc_b) mem[wptr_b] <= db;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            drops <= '0;
        end else begin
            wptr  <= wptr + AW'(acc_a) + AW'(acc_b);
            if (pop && !empty) rptr <= rptr + 1'b1;
            count <= count + (AW+1)'(acc_a) + (AW+1)'(acc_b) - (AW+1)'(pop && !empty);
            drops <= dsum[CW] ? '1 : dsum[CW-1:0];
        end
    end

    // R9: the scheduler never reads an empty queue
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    // R11: a full queue stays full until a word leaves
    a_r11_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);
    // R11: the drop count never goes down
    a_r11_drops_grow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> drops >= $past(drops));

endmodule

// File: rtl/chb_serializer.sv
module chb_serializer #(
    parameter int FW = 42,
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [FW-1:0] frame,
    input  logic [LW-1:0] len,
    output logic          ser_out,
    output logic          ready
);
    logic [FW-1:0] shreg;
    logic [LW-1:0] left;

    // free when idle or when the last bit is on the line
    assign ready   = (left <= LW'(1));
    assign ser_out = (left != '0) ? shreg[FW-1] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            left  <= '0;
        end else if (load) begin
            shreg <= frame;
            left  <= len;
        end else if (left != '0) begin
            shreg <= {shreg[FW-2:0], 1'b1};
            left  <= left - 1'b1;
        end
    end

    // R6: a new frame is loaded only once the current one is on its last bit
    a_r6_no_cut: assert property (@(posedge clk) disable iff (rst)
        load |-> ready);
    // R6: a running frame keeps shifting until it is done
    a_r6_keeps_shifting: assert property (@(posedge clk) disable iff (rst)
        (left > LW'(1)) |=> left == $past(left) - 1'b1);

endmodule

// File: rtl/chb_frame_sched.sv
module chb_frame_sched
    import chb_pkg::*;
#(
    parameter int Q_DEPTH = 128,
    parameter int INH_W   = 8,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INH_W-1:0]   inhibit_len,
    input  logic               pri_req,
    input  logic [5:0]         pri_code,
    input  logic               trg_req,
    input  logic [5:0]         trg_code,
    input  logic               hw_wr,
    input  logic [QWORD_W-1:0] hw_wdata,
    input  logic               sw_wr,
    input  logic [QWORD_W-1:0] sw_wdata,
    output logic               ser_out,
    output logic               q_full,
    output logic [CNT_W-1:0]   drop_cnt
);
    logic               pri_pend, trg_pend;
    logic [5:0]         pri_code_q, trg_code_q;
    logic [INH_W-1:0]   inh_cnt;
    src_e               src;
    logic               load, ser_ready, q_empty;
    logic [FRM_W-1:0]   frm;
    logic [LEN_W-1:0]   flen;
    logic [QWORD_W-1:0] q_rdata;

    chb_queue #(.DEPTH(Q_DEPTH), .W(QWORD_W), .CW(CNT_W)) u_queue (
        .clk(clk), .rst(rst),
        .wa(hw_wr), .da(hw_wdata),
        .wb(sw_wr), .db(sw_wdata),
        .pop(src == SRC_QUE),
        .rdata(q_rdata), .empty(q_empty), .full(q_full), .drops(drop_cnt)
    );

    chb_serializer #(.FW(FRM_W), .LW(LEN_W)) u_ser (
        .clk(clk), .rst(rst),
        .load(load), .frame(frm), .len(flen),
        .ser_out(ser_out), .ready(ser_ready)
    );

    // arbitration: priority frame after its countdown, otherwise lower
    // classes only when no priority frame is pending or being requested
    always_comb begin
        src = SRC_NONE;
        if (ser_ready) begin
            if (pri_pend) begin
                if (inh_cnt == '0) src = SRC_PRI;
            end else if (!pri_req) begin
                if (trg_pend)      src = SRC_TRG;
                else if (!q_empty) src = SRC_QUE;
            end
        end
    end

    assign load = (src != SRC_NONE);

    always_comb begin
        case (src)
            SRC_PRI: begin frm = short_frame(pri_code_q);       flen = LEN_W'(SHORT_BITS); end
            SRC_TRG: begin frm = short_frame(trg_code_q);       flen = LEN_W'(SHORT_BITS); end
            SRC_QUE: begin frm = long_frame(qword_t'(q_rdata)); flen = LEN_W'(LONG_BITS);  end
            default: begin frm = '1;                            flen = '0;                 end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pri_pend   <= 1'b0;
            pri_code_q <= '0;
            inh_cnt    <= '0;
            trg_pend   <= 1'b0;
            trg_code_q <= '0;
        end else begin
            if (pri_pend) begin
                if (src == SRC_PRI)     pri_pend <= 1'b0;
                else if (inh_cnt != '0) inh_cnt  <= inh_cnt - 1'b1;
            end else if (pri_req) begin
                pri_pend   <= 1'b1;
                inh_cnt    <= inhibit_len;
                pri_code_q <= pri_code;
            end
            if (trg_pend) begin
                if (src == SRC_TRG) trg_pend <= 1'b0;
            end else if (trg_req) begin
                trg_pend   <= 1'b1;
                trg_code_q <= trg_code;
            end
        end
    end

    // R5: an expired countdown on a free line launches the priority frame
    a_r5_launch_on_time: assert property (@(posedge clk) disable iff (rst)
        (pri_pend && inh_cnt == '0 && ser_ready) |=> !pri_pend);
    // R5: the inhibit countdown moves one step per clock
    a_r5_countdown: assert property (@(posedge clk) disable iff (rst)
        (pri_pend && inh_cnt != '0) |=> (pri_pend && inh_cnt == $past(inh_cnt) - 1'b1));
    // R8: a waiting priority code is kept until it is sent
    a_r8_pri_kept: assert property (@(posedge clk) disable iff (rst)
        (pri_pend && src != SRC_PRI) |=> (pri_pend && $stable(pri_code_q)));
    // R8: a waiting trigger code is kept until it is sent
    a_r8_trg_kept: assert property (@(posedge clk) disable iff (rst)
        (trg_pend && src != SRC_TRG) |=> (trg_pend && $stable(trg_code_q)));

endmodule

// File: tb/chb_frame_sched_tb.sv
module chb_frame_sched_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  inhibit_len = 8'd16;
    logic        pri_req = 1'b0;
    logic [5:0]  pri_code = '0;
    logic        trg_req = 1'b0;
    logic [5:0]  trg_code = '0;
    logic        hw_wr = 1'b0;
    logic [31:0] hw_wdata = '0;
    logic        sw_wr = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic        ser_out, q_full;
    logic [15:0] drop_cnt;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chb_frame_sched u_dut (
        .clk(clk), .rst(rst), .inhibit_len(inhibit_len),
        .pri_req(pri_req), .pri_code(pri_code),
        .trg_req(trg_req), .trg_code(trg_code),
        .hw_wr(hw_wr), .hw_wdata(hw_wdata),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .ser_out(ser_out), .q_full(q_full), .drop_cnt(drop_cnt)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // reference check bits built by walking code positions
    function automatic logic [6:0] ref_chk(input logic [31:0] d, input int n, input int k);
        logic [6:0] c;
        logic       par;
        int         j;
        c = '0; par = 1'b0; j = 0;
        for (int p = 3; j < n; p++) begin
            if ($countones(p) != 1) begin
                for (int i = 0; i < k; i++)
                    if ((p & (1 << i)) != 0) c[i] = c[i] ^ d[j];
                par = par ^ d[j];
                j++;
            end
        end
        for (int i = 0; i < k; i++) par = par ^ c[i];
        c[k] = par;
        return c;
    endfunction

    function automatic logic [63:0] ref_short(input logic [5:0] code);
        logic [7:0] b;
        logic [6:0] c;
        b = {code, 2'b00};
        c = ref_chk({24'd0, b}, 8, 4);
        return {48'd0, 2'b00, b, c[4:0], 1'b1};
    endfunction

    function automatic logic [63:0] ref_long(input logic [31:0] w);
        logic [31:0] pl;
        logic [6:0]  c;
        pl = {w[30:17], w[16], w[31], w[15:8], w[7:0]};
        c  = ref_chk(pl, 32, 6);
        return {22'd0, 2'b01, pl, c, 1'b1};
    endfunction

    function automatic logic [31:0] hw_word(input int i);
        return 32'h8F3C_1000 ^ (32'(i) * 32'h0001_9A37);
    endfunction

    function automatic logic [31:0] sw_word(input int i);
        return (32'h1234_0000 + 32'(i) * 32'h0000_0103) ^ 32'h4000_0000;
    endfunction

    // counts negedges until the start bit shows, from the current negedge
    task automatic wait_start(output int d);
        d = 0;
        while (ser_out !== 1'b0 && d < 400) begin
            @(negedge clk);
            d++;
        end
        if (d >= 400) check(1'b0, "start bit timeout", 64'(d), 64'd0);
    endtask

    task automatic read_frame(input int len, output logic [63:0] f);
        f = '0;
        f[len-1] = ser_out;
        for (int i = len - 2; i >= 0; i--) begin
            @(negedge clk);
            f[i] = ser_out;
        end
    endtask

    task automatic t_reset();
        check(ser_out === 1'b1, "R1 idle line", 64'(ser_out), 64'd1);
        check(q_full === 1'b0, "R1 q_full after reset", 64'(q_full), 64'd0);
        check(drop_cnt === 16'd0, "R1 drop_cnt after reset", 64'(drop_cnt), 64'd0);
        repeat (5) @(negedge clk);
        check(ser_out === 1'b1, "R1 idle stays high", 64'(ser_out), 64'd1);
    endtask

    task automatic t_trigger();
        int d;
        logic [63:0] f;
        trg_code = 6'h2B; trg_req = 1'b1;
        @(negedge clk); trg_req = 1'b0;
        wait_start(d);
        check(d == 1, "R12 trigger latency", 64'(d), 64'd1);
        read_frame(16, f);
        check(f == ref_short(6'h2B), "R2 R3 trigger frame", f, ref_short(6'h2B));
        @(negedge clk);
        check(ser_out === 1'b1, "R1 idle after frame", 64'(ser_out), 64'd1);
    endtask

    task automatic t_long();
        int d;
        logic [63:0] f;
        hw_wdata = 32'hC5A3_96E1; hw_wr = 1'b1;
        @(negedge clk); hw_wr = 1'b0;
        wait_start(d);
        check(d == 1, "R12 queue latency", 64'(d), 64'd1);
        read_frame(42, f);
        check(f == ref_long(32'hC5A3_96E1), "R4 R3 long frame", f, ref_long(32'hC5A3_96E1));
    endtask

    task automatic t_pri_default();
        int d;
        logic [63:0] f;
        inhibit_len = 8'd16; pri_code = 6'h31; pri_req = 1'b1;
        @(negedge clk); pri_req = 1'b0;
        wait_start(d);
        check(d == 17, "R5 priority launch with 16", 64'(d), 64'd17);
        read_frame(16, f);
        check(f == ref_short(6'h31), "R2 priority frame", f, ref_short(6'h31));
    endtask

    task automatic t_pri_legacy();
        int d;
        logic [63:0] f;
        @(negedge clk);
        hw_wdata = 32'h3E07_B15D; hw_wr = 1'b1;
        @(negedge clk); hw_wr = 1'b0;
        wait_start(d);
        // request priority one clock into the long frame
        inhibit_len = 8'd44; pri_code = 6'h0E; pri_req = 1'b1;
        f = '0;
        f[41] = ser_out;
        for (int i = 40; i >= 0; i--) begin
            @(negedge clk);
            pri_req = 1'b0;
            f[i] = ser_out;
        end
        check(f == ref_long(32'h3E07_B15D), "R6 long frame not cut", f, ref_long(32'h3E07_B15D));
        @(negedge clk);
        wait_start(d);
        check(d == 4, "R5 R6 legacy launch exact", 64'(d), 64'd4);
        read_frame(16, f);
        check(f == ref_short(6'h0E), "R5 legacy priority frame", f, ref_short(6'h0E));
        inhibit_len = 8'd16;
    endtask

    task automatic t_window_order();
        int d;
        logic [63:0] f;
        @(negedge clk);
        inhibit_len = 8'd16; pri_code = 6'h22; pri_req = 1'b1;
        @(negedge clk); pri_req = 1'b0; trg_code = 6'h19; trg_req = 1'b1;
        @(negedge clk); trg_req = 1'b0; hw_wdata = 32'h5A5A_0F0F; hw_wr = 1'b1;
        @(negedge clk); hw_wr = 1'b0;
        wait_start(d);
        check(d == 15, "R6 nothing starts inside the window", 64'(d), 64'd15);
        read_frame(16, f);
        check(f == ref_short(6'h22), "R7 priority first", f, ref_short(6'h22));
        @(negedge clk);
        wait_start(d);
        check(d == 0, "R7 trigger back to back", 64'(d), 64'd0);
        read_frame(16, f);
        check(f == ref_short(6'h19), "R7 trigger second", f, ref_short(6'h19));
        @(negedge clk);
        wait_start(d);
        check(d == 0, "R7 queue back to back", 64'(d), 64'd0);
        read_frame(42, f);
        check(f == ref_long(32'h5A5A_0F0F), "R7 queue third", f, ref_long(32'h5A5A_0F0F));
    endtask

    task automatic t_ignore();
        int d;
        int highs;
        logic [63:0] f;
        @(negedge clk);
        inhibit_len = 8'd20; pri_code = 6'h2A; pri_req = 1'b1;
        @(negedge clk); pri_code = 6'h15;
        @(negedge clk); pri_req = 1'b0; trg_code = 6'h07; trg_req = 1'b1;
        @(negedge clk); trg_code = 6'h38;
        @(negedge clk); trg_req = 1'b0;
        wait_start(d);
        check(d == 18, "R8 first priority timing kept", 64'(d), 64'd18);
        read_frame(16, f);
        check(f == ref_short(6'h2A), "R8 first priority code sent", f, ref_short(6'h2A));
        @(negedge clk);
        read_frame(16, f);
        check(f == ref_short(6'h07), "R8 first trigger code sent", f, ref_short(6'h07));
        highs = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (ser_out === 1'b1) highs++;
        end
        check(highs == 80, "R8 later requests ignored", 64'(highs), 64'd80);
    endtask

    task automatic t_fill();
        int d;
        int bad;
        logic [63:0] f;
        logic [31:0] exp_q [128];
        int ne;
        ne = 0;
        @(negedge clk);
        inhibit_len = 8'd255; pri_code = 6'h3C; pri_req = 1'b1;
        @(negedge clk); pri_req = 1'b0;
        for (int i = 0; i < 63; i++) begin
            hw_wr = 1'b1; hw_wdata = hw_word(i);
            sw_wr = 1'b1; sw_wdata = sw_word(i);
            exp_q[ne] = hw_word(i); exp_q[ne+1] = sw_word(i); ne += 2;
            @(negedge clk);
        end
        hw_wr = 1'b1; hw_wdata = hw_word(63); sw_wr = 1'b0;
        exp_q[ne] = hw_word(63); ne++;
        @(negedge clk);
        check(q_full === 1'b0, "R11 not full at 127", 64'(q_full), 64'd0);
        hw_wr = 1'b1; hw_wdata = hw_word(64); sw_wr = 1'b1; sw_wdata = sw_word(64);
        exp_q[ne] = hw_word(64); ne++;
        @(negedge clk);
        check(q_full === 1'b1, "R11 full at 128", 64'(q_full), 64'd1);
        check(drop_cnt === 16'd1, "R10 only trigger-data word kept", 64'(drop_cnt), 64'd1);
        hw_wdata = hw_word(65); sw_wdata = sw_word(65);
        @(negedge clk);
        hw_wr = 1'b0; sw_wr = 1'b0;
        check(drop_cnt === 16'd3, "R11 drops counted", 64'(drop_cnt), 64'd3);
        wait_start(d);
        check(d == 190, "R5 launch with 255", 64'(d), 64'd190);
        read_frame(16, f);
        check(f == ref_short(6'h3C), "R7 priority before full queue", f, ref_short(6'h3C));
        bad = 0;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            wait_start(d);
            if (d != 0) bad++;
            if (i == 0) check(q_full === 1'b0, "R11 full clears after a pop", 64'(q_full), 64'd0);
            read_frame(42, f);
            if (f != ref_long(exp_q[i])) begin
                bad++;
                if (bad < 4) $display("FAIL R9 R10 word %0d: got %h expected %h", i, f, ref_long(exp_q[i]));
            end
        end
        check(bad == 0, "R9 R10 drain order", 64'(bad), 64'd0);
        @(negedge clk);
        check(ser_out === 1'b1, "R1 idle after drain", 64'(ser_out), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_trigger();
        t_long();
        t_pri_default();
        t_pri_legacy();
        t_window_order();
        t_ignore();
        t_fill();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule